// File: doc/BRIEF.md
# Tag-Snooping Add Reservation Stations

This block is a small group of reservation stations placed in front of one shared, pipelined add/subtract unit. An issue port fills the lowest free station with an operation and two operands. Each operand arrives either as a finished value or as the tag of the unit that will produce it. Stations that are still waiting watch a shared result bus every cycle. When a bus tag matches the tag a waiting operand holds, the station copies the bus data into that operand.

Once both operands of a station hold values, the station may be dispatched into the adder. Only one station is dispatched per cycle, and the lowest-numbered eligible station goes first. A station raises its bus request as soon as it starts executing, two cycles before its result is ready. An external arbiter then grants the bus. After the grant, the station drives its result under its own fixed tag and becomes free again. Each station's tag is its fixed identity, so a later consumer names the value it needs by naming the station that computes it.

Top module: `rsv_add_group`

## Requirements
- R1: After reset every station is free: `issue_ready` is 1, `req_vec` is all zero and `out_valid` is 0.
- R2: A valid issue goes into the lowest-numbered free station. Station i carries the fixed tag BASE_TAG+i (10, 11 and 12 by default). `issue_ready` is 0 while all stations are occupied, and an issue offered then is dropped.
- R3: An operand tag of 0 means the accompanying value is valid. A non-zero tag means the operand waits for the producer with that tag.
- R4: A waiting operand whose tag equals `bus_tag` while `bus_valid` is 1 latches `bus_data`. The two operands of a station match independently. A bus transfer with any other tag changes nothing.
- R5: If the bus carries the matching tag in the same cycle that an operand is issued, the operand captures the bus data at issue.
- R6: A station is dispatched only when both of its operands are valid. At most one station is dispatched per cycle, and the lowest-numbered eligible station goes first. Dispatch happens no earlier than the clock edge after the operands become valid.
- R7: The request bit `req_vec[i]` rises on the edge that dispatches station i. The result is ready two cycles later (the default ADD_LAT is 2).
- R8: The result is `a+b` when `issue_op`=0 and `a-b` when `issue_op`=1, modulo 2^DATA_W, and it appears with the station's own tag.
- R9: A grant to a station whose result is not yet ready is ignored. A grant to a ready station makes `out_valid`, `out_tag` and `out_data` valid one cycle later and frees the station, which can take a new issue in the very next cycle.
- R10: A consumer that waits on another station's tag is not dispatched before that producer's result has been on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue request |
| issue_op | input | 1 | 0 add, 1 subtract (a-b) |
| issue_a_tag | input | TAG_W | Producer tag of operand a, 0 = value valid |
| issue_a_val | input | DATA_W | Value of operand a |
| issue_b_tag | input | TAG_W | Producer tag of operand b, 0 = value valid |
| issue_b_val | input | DATA_W | Value of operand b |
| issue_ready | output | 1 | At least one station is free |
| bus_valid | input | 1 | Result bus carries a transfer |
| bus_tag | input | TAG_W | Tag of the transfer |
| bus_data | input | DATA_W | Data of the transfer |
| gnt | input | NUM_ST | Bus grant per station |
| req_vec | output | NUM_ST | Bus request per station (executing or finished) |
| out_valid | output | 1 | Granted result valid |
| out_tag | output | TAG_W | Tag of the granted station |
| out_data | output | DATA_W | Granted result |

## Verification
Counting from the clock edge that issues a ready operation, dispatch follows one edge later and raises the request bit. The result becomes ready two edges after that, and a grant on the following edge puts it on the outputs. The earliest output therefore appears four edges after the issue edge. The bench drives and samples on falling edges. It checks the request and output pins on each of those falling edges, so an output that arrives one cycle early or late is reported. The scoreboard matches results by order rather than by time, and the checks on individual cycles pin down when dispatch, request and output occur. A snoop on a wrong tag, and an issue offered while every station is full, are checked through the request pins and through the absence of unexpected results.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
   typedef enum logic [1:0] {
      RS_FREE = 2'd0,
      RS_WAIT = 2'd1,
      RS_EXEC = 2'd2,
      RS_DONE = 2'd3
   } rs_state_e;
endpackage

// File: rtl/rsv_pick.sv
// Lowest-index priority picker.
module rsv_pick #(
   parameter int N     = 3,
   parameter int IDX_W = 2
) (
   input  logic [N-1:0]     req,
   output logic             any,
   output logic [IDX_W-1:0] idx
);
   always_comb begin
      any = 1'b0;
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            any = 1'b1;
            idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/rsv_addpipe.sv
// Shared pipelined add/subtract unit; carries the station index with the data.
module rsv_addpipe #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 2,
   parameter int LAT    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [IDX_W-1:0]  in_idx,
   input  logic              in_op,
   input  logic [DATA_W-1:0] in_a,
   input  logic [DATA_W-1:0] in_b,
   output logic              res_valid,
   output logic [IDX_W-1:0]  res_idx,
   output logic [DATA_W-1:0] res_data
);
   logic              stg_v [LAT];
   logic [IDX_W-1:0]  stg_i [LAT];
   logic [DATA_W-1:0] stg_d [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stg_v[0] <= 1'b0;
         stg_i[0] <= '0;
         stg_d[0] <= '0;
      end else begin
         stg_v[0] <= in_valid;
         stg_i[0] <= in_idx;
         stg_d[0] <= in_op ? (in_a - in_b) : (in_a + in_b);
      end
   end

   for (genvar k = 1; k < LAT; k++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            stg_v[k] <= 1'b0;
            stg_i[k] <= '0;
            stg_d[k] <= '0;
         end else begin
            stg_v[k] <= stg_v[k-1];
            stg_i[k] <= stg_i[k-1];
            stg_d[k] <= stg_d[k-1];
         end
      end
   end

   assign res_valid = stg_v[LAT-1];
   assign res_idx   = stg_i[LAT-1];
   assign res_data  = stg_d[LAT-1];
endmodule

// File: rtl/rsv_slot.sv
// One reservation station: control, two tagged operands, held result.
module rsv_slot
   import rsv_pkg::*;
#(
   parameter int TAG_W  = 4,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_we,
   input  logic              issue_op,
   input  logic [TAG_W-1:0]  iss_a_tag,
   input  logic [DATA_W-1:0] iss_a_val,
   input  logic [TAG_W-1:0]  iss_b_tag,
   input  logic [DATA_W-1:0] iss_b_val,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   input  logic              disp_go,
   input  logic              fin_we,
   input  logic [DATA_W-1:0] fin_data,
   input  logic              gnt_sel,
   output logic              is_free,
   output logic              can_go,
   output logic              wants_bus,
   output logic              is_done,
   output logic              op_o,
   output logic [DATA_W-1:0] a_o,
   output logic [DATA_W-1:0] b_o,
   output logic [DATA_W-1:0] res_o
);
   rs_state_e         state;
   logic              op_q;
   logic              a_vld, b_vld;
   logic [TAG_W-1:0]  a_tag, b_tag;
   logic [DATA_W-1:0] a_val, b_val, res_q;
   logic              hit_ia, hit_ib, hit_a, hit_b;

   assign hit_ia = bus_valid && (bus_tag == iss_a_tag);
   assign hit_ib = bus_valid && (bus_tag == iss_b_tag);
   assign hit_a  = bus_valid && !a_vld && (bus_tag == a_tag);
   assign hit_b  = bus_valid && !b_vld && (bus_tag == b_tag);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RS_FREE;
         op_q  <= 1'b0;
         a_vld <= 1'b0;
         b_vld <= 1'b0;
         a_tag <= '0;
         b_tag <= '0;
         a_val <= '0;
         b_val <= '0;
         res_q <= '0;
      end else begin
         case (state)
            RS_FREE: if (issue_we) begin
               state <= RS_WAIT;
               op_q  <= issue_op;
               a_tag <= iss_a_tag;
               b_tag <= iss_b_tag;
               if (iss_a_tag == '0) begin
                  a_vld <= 1'b1;
                  a_val <= iss_a_val;
               end else begin
                  a_vld <= hit_ia;
                  a_val <= bus_data;
               end
               if (iss_b_tag == '0) begin
                  b_vld <= 1'b1;
                  b_val <= iss_b_val;
               end else begin
                  b_vld <= hit_ib;
                  b_val <= bus_data;
               end
            end
            RS_WAIT: begin
               if (hit_a) begin
                  a_vld <= 1'b1;
                  a_val <= bus_data;
               end
               if (hit_b) begin
                  b_vld <= 1'b1;
                  b_val <= bus_data;
               end
               if (disp_go) state <= RS_EXEC;
            end
            RS_EXEC: if (fin_we) begin
               res_q <= fin_data;
               state <= RS_DONE;
            end
            RS_DONE: if (gnt_sel) begin
               state <= RS_FREE;
               a_vld <= 1'b0;
               b_vld <= 1'b0;
            end
            default: state <= RS_FREE;
         endcase
      end
   end

   assign is_free   = (state == RS_FREE);
   assign can_go    = (state == RS_WAIT) && a_vld && b_vld;
   assign wants_bus = (state == RS_EXEC) || (state == RS_DONE);
   assign is_done   = (state == RS_DONE);
   assign op_o      = op_q;
   assign a_o       = a_val;
   assign b_o       = b_val;
   assign res_o     = res_q;
endmodule

// File: rtl/rsv_add_group.sv
// Group of tag-snooping reservation stations sharing one pipelined adder.
module rsv_add_group #(
   parameter int NUM_ST   = 3,
   parameter int TAG_W    = 4,
   parameter int DATA_W   = 32,
   parameter int BASE_TAG = 10,
   parameter int ADD_LAT  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              issue_valid,
   input  logic              issue_op,
   input  logic [TAG_W-1:0]  issue_a_tag,
   input  logic [DATA_W-1:0] issue_a_val,
   input  logic [TAG_W-1:0]  issue_b_tag,
   input  logic [DATA_W-1:0] issue_b_val,
   output logic              issue_ready,
   input  logic              bus_valid,
   input  logic [TAG_W-1:0]  bus_tag,
   input  logic [DATA_W-1:0] bus_data,
   input  logic [NUM_ST-1:0] gnt,
   output logic [NUM_ST-1:0] req_vec,
   output logic              out_valid,
   output logic [TAG_W-1:0]  out_tag,
   output logic [DATA_W-1:0] out_data
);
   localparam int IDX_W = (NUM_ST > 1) ? $clog2(NUM_ST) : 1;

   if (NUM_ST < 1) begin : g_bad_num
      $error("NUM_ST must be at least 1");
   end
   if (ADD_LAT < 1) begin : g_bad_lat
      $error("ADD_LAT must be at least 1");
   end
   if (BASE_TAG < 1 || BASE_TAG + NUM_ST > (1 << TAG_W)) begin : g_bad_tag
      $error("station tags must be non-zero and fit in TAG_W bits");
   end

   logic [NUM_ST-1:0] free_vec, ready_vec, done_vec, busy_vec;
   logic [NUM_ST-1:0] iss_we, dsp_go, fin_we, gnt_sel;
   logic              op_arr [NUM_ST];
   logic [DATA_W-1:0] a_arr [NUM_ST];
   logic [DATA_W-1:0] b_arr [NUM_ST];
   logic [DATA_W-1:0] res_arr [NUM_ST];

   logic              iss_any, dsp_any, g_any;
   logic [IDX_W-1:0]  iss_idx, dsp_idx, g_idx;
   logic              pv;
   logic [IDX_W-1:0]  pidx;
   logic [DATA_W-1:0] pdata;

   rsv_pick #(.N(NUM_ST), .IDX_W(IDX_W)) u_pick_iss (
      .req(free_vec), .any(iss_any), .idx(iss_idx));
   rsv_pick #(.N(NUM_ST), .IDX_W(IDX_W)) u_pick_dsp (
      .req(ready_vec), .any(dsp_any), .idx(dsp_idx));
   rsv_pick #(.N(NUM_ST), .IDX_W(IDX_W)) u_pick_gnt (
      .req(gnt & done_vec), .any(g_any), .idx(g_idx));

   for (genvar i = 0; i < NUM_ST; i++) begin : g_st
      assign iss_we[i]  = issue_valid && iss_any && (iss_idx == IDX_W'(i));
      assign dsp_go[i]  = dsp_any && (dsp_idx == IDX_W'(i));
      assign fin_we[i]  = pv && (pidx == IDX_W'(i));
      assign gnt_sel[i] = g_any && (g_idx == IDX_W'(i));

      rsv_slot #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_slot (
         .clk       (clk),
         .rst_n     (rst_n),
         .issue_we  (iss_we[i]),
         .issue_op  (issue_op),
         .iss_a_tag (issue_a_tag),
         .iss_a_val (issue_a_val),
         .iss_b_tag (issue_b_tag),
         .iss_b_val (issue_b_val),
         .bus_valid (bus_valid),
         .bus_tag   (bus_tag),
         .bus_data  (bus_data),
         .disp_go   (dsp_go[i]),
         .fin_we    (fin_we[i]),
         .fin_data  (pdata),
         .gnt_sel   (gnt_sel[i]),
         .is_free   (free_vec[i]),
         .can_go    (ready_vec[i]),
         .wants_bus (busy_vec[i]),
         .is_done   (done_vec[i]),
         .op_o      (op_arr[i]),
         .a_o       (a_arr[i]),
         .b_o       (b_arr[i]),
         .res_o     (res_arr[i])
      );
   end

   rsv_addpipe #(.DATA_W(DATA_W), .IDX_W(IDX_W), .LAT(ADD_LAT)) u_pipe (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (dsp_any),
      .in_idx    (dsp_idx),
      .in_op     (op_arr[dsp_idx]),
      .in_a      (a_arr[dsp_idx]),
      .in_b      (b_arr[dsp_idx]),
      .res_valid (pv),
      .res_idx   (pidx),
      .res_data  (pdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_tag   <= '0;
         out_data  <= '0;
      end else begin
         out_valid <= g_any;
         out_tag   <= TAG_W'(BASE_TAG) + TAG_W'(g_idx);
         out_data  <= res_arr[g_idx];
      end
   end

   assign issue_ready = iss_any;
   assign req_vec     = busy_vec;
endmodule

// File: rtl/rsv_add_group_chk.sv
module rsv_add_group_chk #(
   parameter int NUM_ST   = 3,
   parameter int TAG_W    = 4,
   parameter int BASE_TAG = 10,
   parameter int IDX_W    = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic [NUM_ST-1:0] gnt,
   input logic [NUM_ST-1:0] req_vec,
   input logic              out_valid,
   input logic [TAG_W-1:0]  out_tag,
   input logic              issue_ready,
   input logic              dsp_any,
   input logic [IDX_W-1:0]  dsp_idx
);
   localparam logic [TAG_W-1:0] TAG_LO = TAG_W'(BASE_TAG);
   localparam logic [TAG_W-1:0] TAG_HI = TAG_W'(BASE_TAG + NUM_ST - 1);

   // R6: a station is never dispatched twice
   assert_dispatch_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_any |-> !req_vec[dsp_idx]);

   // R7: request rises at the dispatch edge
   assert_req_after_dispatch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      dsp_any |=> req_vec[$past(dsp_idx)]);

   // R8: results carry one of the station tags
   assert_out_tag_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_tag >= TAG_LO && out_tag <= TAG_HI));

   // R9: an output needs a grant in the cycle before
   assert_out_needs_grant_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(|gnt));

   // R9: the station that drove the output is free again
   assert_free_after_out_R9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> issue_ready);
endmodule

bind rsv_add_group rsv_add_group_chk #(
   .NUM_ST(NUM_ST), .TAG_W(TAG_W), .BASE_TAG(BASE_TAG), .IDX_W(IDX_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .gnt(gnt), .req_vec(req_vec),
   .out_valid(out_valid), .out_tag(out_tag), .issue_ready(issue_ready),
   .dsp_any(dsp_any), .dsp_idx(dsp_idx)
);

// File: tb/rsv_add_group_tb_top.sv
module rsv_add_group_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int NST = 3;
   localparam int TW  = 4;
   localparam int DW  = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          issue_valid = 1'b0, issue_op = 1'b0;
   logic [TW-1:0] issue_a_tag = '0, issue_b_tag = '0;
   logic [DW-1:0] issue_a_val = '0, issue_b_val = '0;
   logic          issue_ready;
   logic          ext_valid = 1'b0;
   logic [TW-1:0] ext_tag = '0;
   logic [DW-1:0] ext_data = '0;
   logic          bus_valid;
   logic [TW-1:0] bus_tag;
   logic [DW-1:0] bus_data;
   logic [NST-1:0] gnt = '0, req_vec;
   logic          out_valid;
   logic [TW-1:0] out_tag;
   logic [DW-1:0] out_data;
   logic          gnt_en = 1'b1;

   int n_chk = 0, n_fail = 0;
   bit done = 0;
   logic [TW+DW-1:0] exp_q [$];

   always #(CLK_PERIOD / 2) clk = ~clk;

   // result bus: bench injection wins, otherwise the group's own output loops back
   assign bus_valid = ext_valid | out_valid;
   assign bus_tag   = ext_valid ? ext_tag : out_tag;
   assign bus_data  = ext_valid ? ext_data : out_data;

   rsv_add_group dut_i (
      .clk(clk), .rst_n(rst_n),
      .issue_valid(issue_valid), .issue_op(issue_op),
      .issue_a_tag(issue_a_tag), .issue_a_val(issue_a_val),
      .issue_b_tag(issue_b_tag), .issue_b_val(issue_b_val),
      .issue_ready(issue_ready),
      .bus_valid(bus_valid), .bus_tag(bus_tag), .bus_data(bus_data),
      .gnt(gnt), .req_vec(req_vec),
      .out_valid(out_valid), .out_tag(out_tag), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string rq, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
      end
   endtask

   // arbiter: grant the lowest requesting station
   always @(negedge clk) begin
      gnt = '0;
      if (gnt_en) begin
         for (int i = NST - 1; i >= 0; i--) if (req_vec[i]) gnt = NST'(1) << i;
      end
   end

   // monitor: compare each produced result with the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         if (exp_q.size() == 0) begin
            chk(0, "R8 unexpected result", {out_tag, out_data}, 0);
         end else begin
            logic [TW+DW-1:0] e;
            e = exp_q.pop_front();
            chk({out_tag, out_data} == e, "R8 result tag/data", {out_tag, out_data}, e);
         end
      end
   end

   // driver: present an issue at the current falling edge and record the expected result
   task automatic put_issue(input logic op, input logic [TW-1:0] at, input logic [DW-1:0] av,
                            input logic [TW-1:0] bt, input logic [DW-1:0] bv);
      issue_valid = 1'b1; issue_op = op;
      issue_a_tag = at; issue_a_val = av;
      issue_b_tag = bt; issue_b_val = bv;
   endtask

   task automatic expect_res(input int tag, input logic [DW-1:0] d);
      exp_q.push_back({TW'(tag), d});
   endtask

   task automatic idle_issue();
      issue_valid = 1'b0; issue_a_tag = '0; issue_b_tag = '0;
   endtask

   task automatic wait_n(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(issue_ready == 1'b1, "R1 ready after reset", issue_ready, 1);
      chk(req_vec == '0, "R1 no request after reset", req_vec, 0);
      chk(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);

      // R7 R8 R9: ready add, cycle-exact timing; early grants ignored
      put_issue(1'b0, 0, 32'd5, 0, 32'd7);
      expect_res(10, 32'd12);
      @(negedge clk); idle_issue();
      chk(req_vec == '0, "R7 no request before dispatch", req_vec, 0);
      @(negedge clk);
      chk(req_vec == 3'b001, "R7 request at dispatch", req_vec, 3'b001);
      chk(out_valid == 0, "R9 no output yet", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 0, "R9 grant while executing ignored", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 0, "R9 grant before ready ignored", out_valid, 0);
      @(negedge clk);
      chk(out_valid == 1, "R9 output one cycle after effective grant", out_valid, 1);
      chk(out_tag == 4'd10, "R2 station 0 tag", out_tag, 10);
      wait_n(3);

      // R8: subtraction wraps
      put_issue(1'b1, 0, 32'd3, 0, 32'd5);
      expect_res(10, 32'hFFFF_FFFE);
      @(negedge clk); idle_issue();
      wait_n(8);

      // R2 R3 R4 R6: fill all stations waiting on tag 5
      gnt_en = 1'b0;
      for (int i = 0; i < NST; i++) begin
         put_issue(1'b0, 4'd5, 32'hDEAD, 0, DW'(i + 1));
         expect_res(10 + i, DW'(100 + i + 1));
         @(negedge clk);
      end
      idle_issue();
      chk(issue_ready == 0, "R2 not ready when full", issue_ready, 0);
      put_issue(1'b0, 0, 32'd1, 0, 32'd1);   // dropped: no result expected
      @(negedge clk); idle_issue();
      wait_n(2);
      chk(req_vec == '0, "R3 waiting stations not dispatched", req_vec, 0);
      ext_valid = 1'b1; ext_tag = 4'd6; ext_data = 32'd55;
      @(negedge clk); ext_valid = 1'b0;
      @(negedge clk);
      chk(req_vec == '0, "R4 wrong tag ignored", req_vec, 0);
      ext_valid = 1'b1; ext_tag = 4'd5; ext_data = 32'd100;
      @(negedge clk); ext_valid = 1'b0;
      chk(req_vec == 3'b000, "R6 not dispatched on capture edge", req_vec, 0);
      @(negedge clk);
      chk(req_vec == 3'b001, "R6 lowest first", req_vec, 3'b001);
      @(negedge clk);
      chk(req_vec == 3'b011, "R6 one per cycle", req_vec, 3'b011);
      @(negedge clk);
      chk(req_vec == 3'b111, "R6 third dispatch", req_vec, 3'b111);
      gnt_en = 1'b1;
      while (!out_valid) @(negedge clk);
      chk(issue_ready == 1, "R9 freed station ready", issue_ready, 1);
      put_issue(1'b0, 0, 32'd1, 0, 32'd1);  // reuse station 0 at once
      expect_res(10, 32'd2);
      @(negedge clk); idle_issue();
      wait_n(12);

      // R5: bus match on the issue cycle
      gnt_en = 1'b0;
      put_issue(1'b0, 4'd7, 32'h0, 0, 32'd1);
      ext_valid = 1'b1; ext_tag = 4'd7; ext_data = 32'd40;
      expect_res(10, 32'd41);
      @(negedge clk); idle_issue(); ext_valid = 1'b0;
      @(negedge clk);
      chk(req_vec == 3'b001, "R5 captured at issue", req_vec, 3'b001);
      gnt_en = 1'b1;
      wait_n(8);

      // R4: two operands matched independently
      gnt_en = 1'b0;
      put_issue(1'b1, 4'd8, 32'h0, 4'd9, 32'h0);
      expect_res(10, 32'd10);
      @(negedge clk); idle_issue();
      ext_valid = 1'b1; ext_tag = 4'd9; ext_data = 32'd20;
      @(negedge clk); ext_valid = 1'b0;
      @(negedge clk);
      chk(req_vec == '0, "R4 one operand still waiting", req_vec, 0);
      ext_valid = 1'b1; ext_tag = 4'd8; ext_data = 32'd30;
      @(negedge clk); ext_valid = 1'b0;
      gnt_en = 1'b1;
      wait_n(8);

      // R10: consumer waits for producer's broadcast
      put_issue(1'b0, 0, 32'd5, 0, 32'd6);
      expect_res(10, 32'd11);
      @(negedge clk);
      put_issue(1'b0, 4'd10, 32'h0, 0, 32'd1);
      expect_res(11, 32'd12);
      @(negedge clk); idle_issue();
      while (!out_valid) begin
         chk(req_vec[1] == 0, "R10 consumer held before broadcast", req_vec[1], 0);
         @(negedge clk);
      end
      chk(req_vec[1] == 0, "R10 consumer held on broadcast cycle", req_vec[1], 0);
      wait_n(10);

      chk(exp_q.size() == 0, "R8 all results produced", exp_q.size(), 0);
      if (!done) begin
         done = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      end
      $finish;
   end
endmodule